// File: doc/BRIEF.md
# Segmented Page Table Translator

This block maps a 16-bit virtual address to a physical address for a scheme that puts segmentation on top of paging. The two top address bits select the code, heap or stack segment. Each segment has a base register and a limit register. The base register holds the physical address of that segment's own page table. The limit register holds how many pages the segment spans. A request whose page number lies inside the limit causes one read of a 32-bit page table entry. The returned frame number is then joined with the untranslated page offset.

Requests that fail the segment check or the limit check finish without touching memory. Software loads the six registers through a small select/data/write-enable port. A translation is in flight for at most one request at a time, and each request ends with a single `done` pulse that carries either the physical address or a fault code.

Top module: `seg_pt_xlate`

## Requirements
- R1: After reset every base and limit register is zero, `done` and `mem_rd_valid` are low and `req_ready` is high. Because every limit is zero, any request to segment 0, 1 or 2 then reports the bounds fault (code 2).
- R2: The virtual address is divided as follows: segment = bits [15:14], page number = bits [13:9], offset = bits [8:0].
- R3: Segment value 3 yields fault code 1. No memory read is issued, and `done` rises in the cycle after the request is accepted.
- R4: A page number greater than or equal to the segment's limit yields fault code 2. No memory read is issued, and `done` rises in the cycle after acceptance.
- R5: A page number inside the limit issues exactly one read at address base + 4 × page number. `mem_rd_valid` and `mem_rd_addr` stay steady until `mem_rd_ready` is seen high.
- R6: The page table entry layout is: bit 31 = valid, bit 30 = read-only, bits [11:0] = frame number, and all other bits are ignored. An entry with bit 31 clear yields fault code 3.
- R7: A write request (`req_write` = 1) to a valid entry with bit 30 set yields fault code 4. A read request to the same entry succeeds.
- R8: On success, `fault` is 0 and `paddr` = {frame number, offset}. On any fault, `paddr` is 0. For a request that reads memory, `done` rises in the cycle after `mem_rsp_valid`.
- R9: Exactly one `done` pulse is produced for each accepted request. `req_ready` stays low from the acceptance of a request that reads memory until its `done` cycle.
- R10: The configuration select has two parts. `cfg_sel[2]` picks the register kind: 0 = base, 1 = limit. `cfg_sel[1:0]` picks the segment. A select with `cfg_sel[1:0]` = 3 changes nothing. A write takes effect from the next cycle. A request accepted in the same cycle as a write is checked and addressed using the register values from before that write.
- R11: A limit write keeps only `cfg_wdata[5:0]`, so any limit from 0 to 32 pages can be set. A base write keeps all 24 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_vaddr | input | 16 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 3 | {kind, segment} register select |
| cfg_wdata | input | 24 | Register write data |
| mem_rd_valid | output | 1 | Page table entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 24 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Page table entry |
| done | output | 1 | One-cycle result pulse |
| fault | output | 3 | 0 none, 1 segment, 2 bounds, 3 invalid, 4 protection |
| paddr | output | 21 | Physical address, zero on fault |

## Verification
A register write and a request acceptance can land on the same clock edge. If that write hits the limit or base of the segment being translated, the request must still see the old values. The bench provokes this by driving a write together with a request. Both directed cases are used: a limit raised from zero, and a limit lowered to zero. Random requests also sometimes carry a write to a random register. The expected fault and read address are always computed from the bench's register mirror before it applies that write, and the following request is expected to see the new value.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_SEG     = 3'd1,
    FLT_BOUNDS  = 3'd2,
    FLT_INVALID = 3'd3,
    FLT_PROT    = 3'd4
  } fault_e;

  localparam int PTE_W       = 32;
  localparam int PTE_VAL_BIT = 31;
  localparam int PTE_RO_BIT  = 30;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int NSEG   = 3,
  parameter int SEG_W  = 2,
  parameter int ADDR_W = 24,
  parameter int LIM_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEG_W:0]    cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] base_o [NSEG],
  output logic [LIM_W-1:0]  limit_o [NSEG]
);

  logic             sel_limit;
  logic [SEG_W-1:0] sel_idx;

  assign sel_limit = cfg_sel[SEG_W];
  assign sel_idx   = cfg_sel[SEG_W-1:0];

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic hit_base, hit_limit;
    assign hit_base  = cfg_we && !sel_limit && (sel_idx == SEG_W'(i));
    assign hit_limit = cfg_we &&  sel_limit && (sel_idx == SEG_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_o[i]  <= '0;
        limit_o[i] <= '0;
      end else begin
        if (hit_base)  base_o[i]  <= cfg_wdata;
        if (hit_limit) limit_o[i] <= cfg_wdata[LIM_W-1:0];
      end
    end

    AST_CFG_BASE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_sel[SEG_W] && cfg_sel[SEG_W-1:0] == SEG_W'(i))
        |=> base_o[i] == $past(cfg_wdata)); // R10

    AST_CFG_LIMIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel[SEG_W] && cfg_sel[SEG_W-1:0] == SEG_W'(i))
        |=> limit_o[i] == $past(cfg_wdata[LIM_W-1:0])); // R11

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_sel[SEG_W-1:0] == SEG_W'(i))
        |=> $stable(base_o[i]) && $stable(limit_o[i])); // R10
  end

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int NSEG   = 3,
  parameter int SEG_W  = 2,
  parameter int VPN_W  = 5,
  parameter int OFF_W  = 9,
  parameter int ADDR_W = 24,
  parameter int LIM_W  = 6,
  localparam int VA_W  = SEG_W + VPN_W + OFF_W
) (
  input  logic [VA_W-1:0]   vaddr,
  input  logic [ADDR_W-1:0] base_i [NSEG],
  input  logic [LIM_W-1:0]  limit_i [NSEG],
  output logic [OFF_W-1:0]  off_o,
  output logic [ADDR_W-1:0] pte_addr_o,
  output fault_e            early_fault_o,
  output logic              seg_bad_o,
  output logic              over_limit_o
);

  function automatic logic [ADDR_W-1:0] entry_addr(
    input logic [ADDR_W-1:0] base, input logic [VPN_W-1:0] vpn);
    return base + (ADDR_W'(vpn) << 2);
  endfunction

  logic [SEG_W-1:0]  seg;
  logic [VPN_W-1:0]  vpn;
  logic [ADDR_W-1:0] base_sel;
  logic [LIM_W-1:0]  limit_sel;

  assign seg   = vaddr[VA_W-1 -: SEG_W];
  assign vpn   = vaddr[OFF_W +: VPN_W];
  assign off_o = vaddr[OFF_W-1:0];

  always_comb begin
    base_sel  = '0;
    limit_sel = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (seg == SEG_W'(i)) begin
        base_sel  = base_i[i];
        limit_sel = limit_i[i];
      end
    end
  end

  assign seg_bad_o    = (32'(seg) >= NSEG);
  assign over_limit_o = (LIM_W'(vpn) >= limit_sel);
  assign pte_addr_o   = entry_addr(base_sel, vpn);

  always_comb begin
    if (seg_bad_o)         early_fault_o = FLT_SEG;
    else if (over_limit_o) early_fault_o = FLT_BOUNDS;
    else                   early_fault_o = FLT_NONE;
  end

endmodule

// File: rtl/seg_walk.sv
module seg_walk
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W  = 9,
  parameter int PFN_W  = 12,
  parameter int ADDR_W = 24,
  localparam int PA_W  = PFN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  fault_e            early_fault,
  input  logic [ADDR_W-1:0] pte_addr,
  input  logic [OFF_W-1:0]  off,
  output logic              req_ready,
  output logic              accept_o,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              done,
  output fault_e            fault,
  output logic [PA_W-1:0]   paddr
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;

  function automatic fault_e entry_fault(input logic [PTE_W-1:0] d, input logic wr);
    if (!d[PTE_VAL_BIT])         return FLT_INVALID;
    else if (wr && d[PTE_RO_BIT]) return FLT_PROT;
    else                          return FLT_NONE;
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PTE_W-1:0] d,
                                              input logic [OFF_W-1:0] o);
    return {d[PFN_W-1:0], o};
  endfunction

  st_e               state;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [OFF_W-1:0]  off_q;
  logic              rsp_take;
  fault_e            rsp_fault;
  logic              unused_pte_bits;

  assign unused_pte_bits = ^mem_rsp_data[PTE_RO_BIT-1:PFN_W];

  assign req_ready    = (state == ST_IDLE);
  assign accept_o     = req_valid && req_ready;
  assign mem_rd_valid = (state == ST_ISSUE);
  assign mem_rd_addr  = addr_q;
  assign rsp_take     = (state == ST_WAIT) && mem_rsp_valid;
  assign rsp_fault    = entry_fault(mem_rsp_data, wr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      wr_q   <= 1'b0;
      off_q  <= '0;
      done   <= 1'b0;
      fault  <= FLT_NONE;
      paddr  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept_o) begin
            if (early_fault != FLT_NONE) begin
              done  <= 1'b1;
              fault <= early_fault;
              paddr <= '0;
            end else begin
              state  <= ST_ISSUE;
              addr_q <= pte_addr;
              wr_q   <= req_write;
              off_q  <= off;
            end
          end
        end
        ST_ISSUE: if (mem_rd_ready) state <= ST_WAIT;
        ST_WAIT: begin
          if (rsp_take) begin
            done  <= 1'b1;
            fault <= rsp_fault;
            paddr <= (rsp_fault == FLT_NONE) ? join_pa(mem_rsp_data, off_q) : '0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && early_fault != FLT_NONE)
      |=> done && fault == $past(early_fault) && !mem_rd_valid); // R4

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> mem_rd_valid && $stable(mem_rd_addr)); // R5

  AST_RD_ADDR_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && early_fault == FLT_NONE) |=> mem_rd_valid && mem_rd_addr == $past(pte_addr)); // R5

  AST_RSP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |=> done && req_ready); // R8

  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != FLT_NONE) |-> paddr == '0); // R8

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(accept_o)) |-> $past(rsp_take)); // R9

endmodule

// File: rtl/seg_pt_xlate.sv
module seg_pt_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NSEG   = 3,
  parameter int SEG_W  = 2,
  parameter int VPN_W  = 5,
  parameter int OFF_W  = 9,
  parameter int PFN_W  = 12,
  parameter int ADDR_W = 24,
  localparam int VA_W  = SEG_W + VPN_W + OFF_W,
  localparam int PA_W  = PFN_W + OFF_W,
  localparam int LIM_W = VPN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic              cfg_we,
  input  logic [SEG_W:0]    cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              done,
  output logic [2:0]        fault,
  output logic [PA_W-1:0]   paddr
);

  logic [ADDR_W-1:0] base_w  [NSEG];
  logic [LIM_W-1:0]  limit_w [NSEG];
  logic [OFF_W-1:0]  off_w;
  logic [ADDR_W-1:0] pte_addr_w;
  fault_e            early_w;
  fault_e            fault_w;
  logic              seg_bad_w, over_limit_w, accept_w;

  seg_regfile #(.NSEG(NSEG), .SEG_W(SEG_W), .ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .base_o(base_w), .limit_o(limit_w)
  );

  seg_check #(.NSEG(NSEG), .SEG_W(SEG_W), .VPN_W(VPN_W), .OFF_W(OFF_W),
              .ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_check (
    .vaddr(req_vaddr), .base_i(base_w), .limit_i(limit_w), .off_o(off_w),
    .pte_addr_o(pte_addr_w), .early_fault_o(early_w),
    .seg_bad_o(seg_bad_w), .over_limit_o(over_limit_w)
  );

  seg_walk #(.OFF_W(OFF_W), .PFN_W(PFN_W), .ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .early_fault(early_w), .pte_addr(pte_addr_w), .off(off_w),
    .req_ready(req_ready), .accept_o(accept_w),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault_w), .paddr(paddr)
  );

  assign fault = fault_w;

  AST_SEG_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && seg_bad_w) |=> done && fault == 3'd1); // R3

  AST_BOUNDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !seg_bad_w && over_limit_w) |=> done && fault == 3'd2 && !mem_rd_valid); // R4

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> req_ready && !done && !mem_rd_valid); // R1

endmodule

// File: tb/seg_pt_xlate_tb.sv
module seg_pt_xlate_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_vaddr = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [23:0] cfg_wdata = '0;
  logic        mem_rd_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        req_ready, mem_rd_valid, done;
  logic [23:0] mem_rd_addr;
  logic [2:0]  fault;
  logic [20:0] paddr;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [23:0] m_base [3];
  logic [5:0]  m_lim [3];
  bit          force_en = 1'b0;
  logic [31:0] force_pte = '0;

  always #4 clk = ~clk;

  seg_pt_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .paddr(paddr)
  );

  function automatic logic [31:0] pte_of(input logic [23:0] a);
    logic [31:0] h;
    if (force_en) return force_pte;
    h = {8'h0, a} * 32'h9E3779B1;
    h = h ^ (h >> 13);
    return h;
  endfunction

  task automatic chk(input string tag, input bit ok, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic mirror_write(input logic [2:0] sel, input logic [23:0] d);
    if (sel[1:0] != 2'd3) begin
      if (sel[2]) m_lim[sel[1:0]] = d[5:0];
      else        m_base[sel[1:0]] = d;
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    mirror_write(sel, d);
  endtask

  task automatic do_req(input logic [15:0] va, input bit wr, input bit cwe,
                        input logic [2:0] csel, input logic [23:0] cdat, input string tagx);
    int ef, exp_reads, reads, dones, rdv_seen, dly;
    logic [23:0] eaddr;
    logic [31:0] pte;
    logic [20:0] epa;
    logic [2:0]  got_f;
    logic [20:0] got_pa;
    bit rdy_set, pend, rsp_on, ready_low_ok;
    string tag;
    logic [1:0] seg;
    logic [4:0] vpn;
    seg = va[15:14]; vpn = va[13:9];
    eaddr = '0; epa = '0; exp_reads = 0;
    if (seg == 2'd3) ef = 1;
    else if ({1'b0, vpn} >= m_lim[seg]) ef = 2;
    else begin
      eaddr = m_base[seg] + {17'd0, vpn, 2'b00};
      pte = pte_of(eaddr);
      exp_reads = 1;
      if (!pte[31]) ef = 3;
      else if (wr && pte[30]) ef = 4;
      else begin ef = 0; epa = {pte[11:0], va[8:0]}; end
    end
    case (ef)
      1: tag = "R3"; 2: tag = "R4"; 3: tag = "R6"; 4: tag = "R7"; default: tag = "R8";
    endcase
    if (tagx != "") tag = tagx;
    @(negedge clk);
    chk("R9", req_ready == 1'b1, "ready before request", req_ready, 1);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    cfg_we = cwe; cfg_sel = csel; cfg_wdata = cdat;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    if (cwe) mirror_write(csel, cdat);
    reads = 0; dones = 0; rdv_seen = 0; rdy_set = 0; pend = 0; rsp_on = 0; dly = 0;
    ready_low_ok = 1; got_f = '0; got_pa = '0;
    for (int c = 0; c < 20; c++) begin
      if (done) begin dones++; got_f = fault; got_pa = paddr; end
      if (rsp_on) begin rsp_on = 0; mem_rsp_valid = 1'b0; end
      if (rdy_set) begin
        rdy_set = 0; mem_rd_ready = 1'b0; reads++; pend = 1; dly = int'($urandom % 3);
      end else if (pend) begin
        if (dly == 0) begin
          pend = 0; rsp_on = 1; mem_rsp_valid = 1'b1; mem_rsp_data = pte_of(eaddr);
        end else dly--;
      end else if (mem_rd_valid) begin
        rdv_seen++;
        if (req_ready) ready_low_ok = 0;
        if (rdv_seen == 1)
          chk("R5", mem_rd_addr == eaddr, "read address", mem_rd_addr, eaddr);
        else
          chk("R5", mem_rd_addr == eaddr, "held read address", mem_rd_addr, eaddr);
        if ($urandom % 2 == 0) begin rdy_set = 1; mem_rd_ready = 1'b1; end
      end
      if (c == 0 && exp_reads == 0)
        chk(tag, done == 1'b1, "done one cycle after accept", done, 1);
      @(negedge clk);
    end
    chk("R5", reads == exp_reads, "memory reads", reads, exp_reads);
    chk("R9", dones == 1, "done pulses", dones, 1);
    chk("R9", ready_low_ok, "ready low during walk", ready_low_ok, 1);
    chk(tag, got_f == 3'(ef), "fault code", got_f, ef);
    chk("R8", got_pa == epa, "physical address", got_pa, epa);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3; i++) begin m_base[i] = '0; m_lim[i] = '0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", done == 1'b0 && mem_rd_valid == 1'b0, "idle outputs", {done, mem_rd_valid}, 0);
    chk("R1", req_ready == 1'b1, "ready after reset", req_ready, 1);
    do_req(16'h0000, 1'b0, 0, 3'd0, '0, "R1");
    do_req(16'h4A35, 1'b1, 0, 3'd0, '0, "R1");
    do_req(16'hC123, 1'b0, 0, 3'd0, '0, "R3");

    // R2: field split at the top page of a full segment
    cfg_write(3'b001, 24'h001000);
    cfg_write(3'b101, 24'd32);
    force_en = 1; force_pte = 32'h8000_0ABC;
    do_req({2'd1, 5'd31, 9'h1FF}, 1'b0, 0, 3'd0, '0, "R2");
    do_req({2'd1, 5'd0, 9'h000}, 1'b1, 0, 3'd0, '0, "R2");
    // R6: invalid entry, upper bits ignored
    force_pte = 32'h3FFF_F123;
    do_req({2'd1, 5'd3, 9'h055}, 1'b0, 0, 3'd0, '0, "R6");
    force_pte = 32'hBFFF_F456;
    do_req({2'd1, 5'd4, 9'h0AA}, 1'b0, 0, 3'd0, '0, "R6");
    // R7: read-only entry
    force_pte = 32'hC000_0789;
    do_req({2'd1, 5'd7, 9'h101}, 1'b1, 0, 3'd0, '0, "R7");
    do_req({2'd1, 5'd7, 9'h101}, 1'b0, 0, 3'd0, '0, "R7");
    force_en = 0;

    // R11: limit keeps low six bits only
    cfg_write(3'b100, 24'hFFFFC5);
    cfg_write(3'b000, 24'hABCDEF);
    do_req({2'd0, 5'd5, 9'h010}, 1'b0, 0, 3'd0, '0, "R11");
    do_req({2'd0, 5'd4, 9'h010}, 1'b0, 0, 3'd0, '0, "R11");
    // R10: segment field 3 writes change nothing
    cfg_write(3'b111, 24'd0);
    cfg_write(3'b011, 24'h000000);
    do_req({2'd0, 5'd4, 9'h020}, 1'b0, 0, 3'd0, '0, "R10");
    do_req({2'd1, 5'd31, 9'h020}, 1'b1, 0, 3'd0, '0, "R10");
    // R10: same-cycle write uses old values
    cfg_write(3'b110, 24'd0);
    do_req({2'd2, 5'd0, 9'h001}, 1'b0, 1, 3'b110, 24'd10, "R10");
    do_req({2'd2, 5'd9, 9'h001}, 1'b0, 0, 3'd0, '0, "R10");
    do_req({2'd2, 5'd2, 9'h002}, 1'b0, 1, 3'b110, 24'd0, "R10");
    do_req({2'd2, 5'd2, 9'h002}, 1'b0, 0, 3'd0, '0, "R10");
    do_req({2'd1, 5'd6, 9'h003}, 1'b0, 1, 3'b001, 24'h777000, "R10");
    do_req({2'd1, 5'd6, 9'h003}, 1'b0, 0, 3'd0, '0, "R10");

    for (int n = 0; n < 300; n++) begin
      logic [15:0] va;
      bit cwe;
      if (n % 50 == 0)
        for (int s = 0; s < 3; s++) begin
          cfg_write({1'b0, 2'(s)}, 24'($urandom));
          cfg_write({1'b1, 2'(s)}, 24'($urandom % 33));
        end
      va = 16'($urandom);
      if (va[15:14] == 2'd3 && ($urandom % 4 != 0)) va[15:14] = 2'($urandom % 3);
      cwe = ($urandom % 8 == 0);
      do_req(va, 1'($urandom), cwe, 3'($urandom),
             ($urandom % 2) ? 24'($urandom % 33) : 24'($urandom), "");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule